// File: doc/BRIEF.md
# Digest Block Fetch Controller

This block sits between a host register bus and a hash compression core. The host programs three 16-bit values through byte-wide registers: a source pointer, a destination pointer and a message length. It then writes a start code. The controller reads the message from a byte-wide shared memory, 64 bytes at a time, and packs each block into a 512-bit word. It hands every block to the external core over a request/done pair. When the bytes consumed reach or pass the length, it stores the core's 160-bit result as 20 bytes at the destination pointer and returns to idle.

The memory port returns read data one cycle after the address. It carries one byte access per cycle and is never used for a read and a write in the same cycle. A configuration input chooses the byte order. It applies both to the packing of the block and to the order in which the digest bytes are written out.

Top module: `dfc_top`

## Requirements
- R1: After reset the sequencer is idle (state code 0), `host_rdata` is 0, and `mem_re`, `mem_we` and `hash_req` are low.
- R2: The register window is host addresses 0xFE00–0xFE0F. A write command is `cmd`=2 and a read command is `cmd`=1. Offset 1/2 hold the source pointer low/high byte, offset 3/4 the destination pointer low/high byte, and offset 5/6 the length low/high byte. A read returns the addressed byte in `host_rdata` one cycle later. Offsets 7–15 read 0. A write outside the window changes nothing.
- R3: Register writes take effect only while the state is idle. A write in any other state, including the cycle of the last digest byte, is dropped.
- R4: Writing 1 to offset 0 while idle moves the state to 1 (fetch) on the next clock and clears the consumed-bytes count. Any other value written there leaves the state idle.
- R5: In fetch, the controller issues 64 reads on 64 consecutive cycles. The addresses are source + consumed + i for i = 0..63, with 16-bit wrap. Each byte is taken from `mem_rdata` one cycle after its address.
- R6: With `cfg_big_end`=1, the byte read at offset i lands in bits [511-8i -: 8] of `hash_block`. With `cfg_big_end`=0, it lands in bits [8i +: 8].
- R7: After the 64th byte, the consumed count grows by 64 and `hash_req` is high for exactly one cycle (state 2). The controller then waits in state 3 for `hash_done`. A `hash_done` outside state 3 has no effect.
- R8: When `hash_done` arrives in state 3, the controller goes back to fetch if consumed < length, and otherwise to state 4. A length of N therefore takes max(1, ceil(N/64)) blocks.
- R9: In state 4, the controller writes 20 bytes on consecutive cycles to destination + k, for k = 0..19. Byte k is digest[159-8k -: 8] when `cfg_big_end`=1 and digest[8k +: 8] when it is 0. After the last byte the state returns to idle.
- R10: A read of offset 0 returns the state code (0 idle, 1 fetch, 2 request, 3 wait, 4 store), zero-extended to 8 bits, in any state.
- R11: `host_rdata` changes only on a read command inside the window. Other commands and addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Host command: 1 read, 2 write, others idle |
| cmd_addr | input | 16 | Host address |
| cmd_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered readback byte |
| cfg_big_end | input | 1 | 1: big-endian packing, 0: little-endian |
| mem_addr | output | 16 | Shared memory byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| hash_req | output | 1 | One-cycle request to the hash core |
| hash_block | output | 512 | Packed message block |
| hash_done | input | 1 | Hash core completion pulse |
| hash_digest | input | 160 | Hash core result, valid with `hash_done` |

## Verification
A host write and the sequencer's return to idle can fall on the same clock edge. The bench waits until it sees the write strobe for the twentieth digest byte. In that same cycle it issues a register write, and it issues a second write one cycle later. It then reads both registers back: the first write must be lost and the second must have landed. A stray `hash_done` is also injected while the block is still being fetched. It must leave the read sequence, the block handed to the core and the digest bytes exactly as the scoreboard predicts.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_HREQ  = 3'd2,
    ST_HWAIT = 3'd3,
    ST_STORE = 3'd4
  } dfc_state_e;

  localparam logic [1:0] CMD_RD     = 2'd1;
  localparam logic [1:0] CMD_WR     = 2'd2;
  localparam int         CFG_BYTES  = 6;
  localparam logic [7:0] START_CODE = 8'd1;

  // Byte lane for element idx of an n-byte word under the chosen order.
  function automatic int lane_of(input int idx, input int n, input logic big_end);
    return big_end ? (n - 1 - idx) : idx;
  endfunction
endpackage

// File: rtl/dfc_regs.sv
module dfc_regs
  import dfc_pkg::*;
#(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   WIN_BASE = 16'hFE00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cmd,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [7:0]      cmd_wdata,
  input  dfc_state_e      state,
  output logic [AW-1:0]   rd_base,
  output logic [AW-1:0]   wr_base,
  output logic [AW-1:0]   op_len,
  output logic            start,
  output logic [7:0]      host_rdata
);
  localparam int OFS_W = 4;

  logic [7:0]       bank [CFG_BYTES];
  logic             win_hit, wr_en;
  logic [OFS_W-1:0] ofs;
  logic [7:0]       rd_val;

  assign ofs     = cmd_addr[OFS_W-1:0];
  assign win_hit = (cmd_addr[AW-1:OFS_W] == WIN_BASE[AW-1:OFS_W]);
  assign wr_en   = (cmd == CMD_WR) && win_hit && (state == ST_IDLE);
  assign start   = wr_en && (ofs == '0) && (cmd_wdata == START_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CFG_BYTES; k++) bank[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < CFG_BYTES; k++)
        if (ofs == OFS_W'(k + 1)) bank[k] <= cmd_wdata;
    end
  end

  assign rd_base = {bank[1], bank[0]};
  assign wr_base = {bank[3], bank[2]};
  assign op_len  = {bank[5], bank[4]};

  always_comb begin
    rd_val = '0;
    if (ofs == '0) rd_val = 8'(state);
    for (int k = 0; k < CFG_BYTES; k++)
      if (ofs == OFS_W'(k + 1)) rd_val = bank[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          host_rdata <= '0;
    else if (cmd == CMD_RD && win_hit)   host_rdata <= rd_val;
  end
endmodule

// File: rtl/dfc_gather.sv
module dfc_gather
  import dfc_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  localparam int BI_W     = $clog2(BLK_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_vld,
  input  logic [BI_W-1:0]        cap_idx,
  input  logic [7:0]             cap_byte,
  input  logic                   big_end,
  output logic [BLK_BYTES*8-1:0] block
);
  logic [7:0]      lane [BLK_BYTES];
  logic [BI_W-1:0] tgt;

  assign tgt = BI_W'(lane_of(int'(cap_idx), BLK_BYTES, big_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < BLK_BYTES; g++) lane[g] <= '0;
    end else if (cap_vld) begin
      lane[tgt] <= cap_byte;
    end
  end

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_pack
    assign block[g*8 +: 8] = lane[g];
  end
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_BYTES = 64,
  parameter int DIG_BYTES = 20,
  localparam int BI_W     = $clog2(BLK_BYTES),
  localparam int IDX_W    = $clog2(BLK_BYTES + 1),
  localparam int WIDX_W   = $clog2(DIG_BYTES),
  localparam int DIG_W    = DIG_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     rd_base,
  input  logic [AW-1:0]     wr_base,
  input  logic [AW-1:0]     op_len,
  input  logic              big_end,
  input  logic              hash_done,
  input  logic [DIG_W-1:0]  hash_digest,
  output dfc_state_e        state,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              hash_req,
  output logic              cap_vld,
  output logic [BI_W-1:0]   cap_idx,
  output logic              blk_done
);
  logic [AW-1:0]     consumed;
  logic [IDX_W-1:0]  issue_cnt;
  logic [WIDX_W-1:0] wr_cnt;
  logic [DIG_W-1:0]  digest_q;
  logic              issuing;
  int                dlane;

  assign issuing  = (state == ST_FETCH) && (issue_cnt < IDX_W'(BLK_BYTES));
  assign blk_done = cap_vld && (cap_idx == BI_W'(BLK_BYTES - 1));
  assign hash_req = (state == ST_HREQ);
  assign mem_re   = issuing;
  assign mem_we   = (state == ST_STORE);
  assign mem_addr = (state == ST_STORE) ? (wr_base + AW'(wr_cnt))
                                        : (rd_base + consumed + AW'(issue_cnt));
  assign dlane     = lane_of(int'(wr_cnt), DIG_BYTES, big_end);
  assign mem_wdata = digest_q[dlane*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_vld <= issuing;
      cap_idx <= issue_cnt[BI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      consumed  <= '0;
      issue_cnt <= '0;
      wr_cnt    <= '0;
      digest_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_FETCH;
          consumed  <= '0;
          issue_cnt <= '0;
        end
        ST_FETCH: begin
          if (issuing) issue_cnt <= issue_cnt + 1'b1;
          if (blk_done) begin
            state     <= ST_HREQ;
            consumed  <= consumed + AW'(BLK_BYTES);
            issue_cnt <= '0;
          end
        end
        ST_HREQ: state <= ST_HWAIT;
        ST_HWAIT: if (hash_done) begin
          digest_q <= hash_digest;
          wr_cnt   <= '0;
          state    <= (consumed < op_len) ? ST_FETCH : ST_STORE;
        end
        ST_STORE: begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == WIDX_W'(DIG_BYTES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfc_top.sv
module dfc_top
  import dfc_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [15:0]   WIN_BASE  = 16'hFE00,
  parameter int            BLK_BYTES = 64,
  parameter int            DIG_BYTES = 20,
  localparam int           BLK_W     = BLK_BYTES * 8,
  localparam int           DIG_W     = DIG_BYTES * 8,
  localparam int           BI_W      = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [7:0]       cmd_wdata,
  output logic [7:0]       host_rdata,
  input  logic             cfg_big_end,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_re,
  input  logic [7:0]       mem_rdata,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  output logic             hash_req,
  output logic [BLK_W-1:0] hash_block,
  input  logic             hash_done,
  input  logic [DIG_W-1:0] hash_digest
);
  dfc_state_e      st;
  logic [AW-1:0]   rd_base, wr_base, op_len;
  logic            start, cap_vld, blk_done;
  logic [BI_W-1:0] cap_idx;

  dfc_regs #(.AW(AW), .WIN_BASE(AW'(WIN_BASE))) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .state(st), .rd_base(rd_base),
    .wr_base(wr_base), .op_len(op_len), .start(start),
    .host_rdata(host_rdata)
  );

  dfc_seq #(.AW(AW), .BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_base(rd_base),
    .wr_base(wr_base), .op_len(op_len), .big_end(cfg_big_end),
    .hash_done(hash_done), .hash_digest(hash_digest), .state(st),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .hash_req(hash_req), .cap_vld(cap_vld),
    .cap_idx(cap_idx), .blk_done(blk_done)
  );

  dfc_gather #(.BLK_BYTES(BLK_BYTES)) u_gather (
    .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .cap_byte(mem_rdata), .big_end(cfg_big_end), .block(hash_block)
  );
endmodule

// File: rtl/dfc_chk.sv
module dfc_chk
  import dfc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DIG_BYTES = 20
) (
  input logic          clk,
  input logic          rst_n,
  input dfc_state_e    state,
  input logic          start,
  input logic          blk_done,
  input logic [AW-1:0] rd_base,
  input logic [AW-1:0] mem_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic          hash_req,
  input logic          hash_done
);
  logic [7:0] we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      we_run <= '0;
    else if (mem_we) we_run <= we_run + 1'b1;
    else             we_run <= '0;
  end

  a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r3_regs_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(rd_base));

  a_r4_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> (state == ST_FETCH));

  a_r5_read_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req |=> !hash_req);

  a_r7_req_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hash_req) |-> $past(blk_done));

  a_r8_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HWAIT && hash_done) |=> (state == ST_FETCH || state == ST_STORE));

  a_r9_write_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r9_write_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we) |-> (we_run == 8'(DIG_BYTES)));

  a_r9_write_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
    we_run <= 8'(DIG_BYTES));
endmodule

bind dfc_top dfc_chk #(.AW(AW), .DIG_BYTES(DIG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st), .start(start), .blk_done(blk_done),
  .rd_base(rd_base), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
  .hash_req(hash_req), .hash_done(hash_done)
);

// File: tb/sim_dfc_top.sv
module sim_dfc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd = '0;
  logic [15:0]  cmd_addr = '0;
  logic [7:0]   cmd_wdata = '0;
  logic [7:0]   host_rdata;
  logic         cfg_big_end = 1'b0;
  logic [15:0]  mem_addr;
  logic         mem_re, mem_we;
  logic [7:0]   mem_rdata = '0;
  logic [7:0]   mem_wdata;
  logic         hash_req;
  logic [511:0] hash_block;
  logic         hash_done = 1'b0;
  logic [159:0] hash_digest = '0;

  int n_chk = 0, n_err = 0;
  logic [15:0]  q_rd  [$];
  logic [511:0] q_blk [$];
  logic [23:0]  q_wr  [$];
  logic         stray_req = 1'b0;
  logic         prev_req = 1'b0;

  always #4 clk = ~clk;

  dfc_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .host_rdata(host_rdata), .cfg_big_end(cfg_big_end),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .hash_req(hash_req),
    .hash_block(hash_block), .hash_done(hash_done), .hash_digest(hash_digest)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  function automatic logic [159:0] hfn(input logic [511:0] b);
    return b[159:0] ^ b[511:352] ^ {5{32'hC3A51F07}};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) mem_rdata <= mem_fn(mem_addr);

  // hash core model
  initial begin
    logic [511:0] latched;
    int hd_cnt;
    latched = '0;
    hd_cnt = 0;
    forever begin
      @(negedge clk);
      hash_done = 1'b0;
      if (stray_req) begin
        hash_done = 1'b1;
        hash_digest = 160'hBAD0_BAD0;
        stray_req = 1'b0;
      end
      if (hd_cnt != 0) begin
        hd_cnt--;
        if (hd_cnt == 0) begin
          hash_done = 1'b1;
          hash_digest = hfn(latched);
        end
      end
      if (hash_req) begin
        latched = hash_block;
        hd_cnt = 4;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_re) begin
          if (q_rd.size() == 0) chk(1'b0, "R5 unexpected read", 512'(mem_addr), 0);
          else begin
            logic [15:0] e;
            e = q_rd.pop_front();
            chk(mem_addr == e, "R5 read address", 512'(mem_addr), 512'(e));
          end
        end
        if (hash_req) begin
          chk(!prev_req, "R7 request longer than one cycle", 1, 0);
          if (q_blk.size() == 0) chk(1'b0, "R7 unexpected request", 1, 0);
          else begin
            logic [511:0] eb;
            eb = q_blk.pop_front();
            chk(hash_block == eb, "R6 packed block", hash_block, eb);
          end
        end
        prev_req = hash_req;
        if (mem_we) begin
          if (q_wr.size() == 0) chk(1'b0, "R9 unexpected write", 512'(mem_addr), 0);
          else begin
            logic [23:0] ew;
            ew = q_wr.pop_front();
            chk({mem_addr, mem_wdata} == ew, "R9 digest write addr/data",
                512'({mem_addr, mem_wdata}), 512'(ew));
          end
        end
      end
    end
  end

  task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
    cmd = 2'd2; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic host_rd(input logic [15:0] a, output logic [7:0] d);
    cmd = 2'd1; cmd_addr = a;
    @(negedge clk);
    cmd = 2'd0;
    d = host_rdata;
  endtask

  // driver: pushes expectations, programs and starts one operation
  task automatic run_op(input logic [15:0] rd, input logic [15:0] wr,
                        input logic [15:0] len, input logic be, input int mode);
    int nb;
    logic [511:0] blk;
    logic [159:0] dg;
    logic [7:0] v;
    logic seen1, seen3, seen4, bad;
    nb = (len == 0) ? 1 : (int'(len) + 63) / 64;
    blk = '0;
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < 64; i++) begin
        logic [15:0] a;
        a = rd + 16'(64 * b + i);
        q_rd.push_back(a);
        if (be) blk[511 - 8*i -: 8] = mem_fn(a);
        else    blk[8*i +: 8] = mem_fn(a);
      end
      q_blk.push_back(blk);
    end
    dg = hfn(blk);
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d;
      d = be ? dg[159 - 8*k -: 8] : dg[8*k +: 8];
      q_wr.push_back({wr + 16'(k), d});
    end
    cfg_big_end = be;
    host_wr(16'hFE01, rd[7:0]);  host_wr(16'hFE02, rd[15:8]);
    host_wr(16'hFE03, wr[7:0]);  host_wr(16'hFE04, wr[15:8]);
    host_wr(16'hFE05, len[7:0]); host_wr(16'hFE06, len[15:8]);
    host_wr(16'hFE00, 8'd1);
    host_wr(16'hFE01, ~rd[7:0]);           // busy write, must be dropped (R3)
    if (mode != 2) begin
      host_rd(16'hFE00, v);
      chk(v == 8'd1, "R4 state after start", 512'(v), 1);
      seen1 = 1'b0; seen3 = 1'b0; seen4 = 1'b0; bad = 1'b0;
      for (int n = 0; n < 3000 && v != 0; n++) begin
        if (mode == 1 && n == 6) stray_req = 1'b1;
        if (v == 1) seen1 = 1'b1;
        if (v == 3) seen3 = 1'b1;
        if (v == 4) seen4 = 1'b1;
        if (v > 4) bad = 1'b1;
        host_rd(16'hFE00, v);
      end
      chk(v == 0, "R9 return to idle", 512'(v), 0);
      chk(seen1 && seen3 && seen4 && !bad, "R10 state codes observed",
          512'({bad, seen4, seen3, seen1}), 512'(4'b0111));
    end else begin
      for (int n = 0; n < 3000; n++) begin
        @(negedge clk);
        if (mem_we && mem_addr == wr + 16'd19) break;
      end
      host_wr(16'hFE05, 8'hAA);   // same edge as last digest byte: dropped
      host_wr(16'hFE06, 8'hBB);   // first idle cycle: accepted
      host_rd(16'hFE05, v);
      chk(v == len[7:0], "R3 write on final store cycle dropped", 512'(v), 512'(len[7:0]));
      host_rd(16'hFE06, v);
      chk(v == 8'hBB, "R3 write right after idle accepted", 512'(v), 512'hBB);
      host_rd(16'hFE00, v);
      chk(v == 0, "R9 idle after store", 512'(v), 0);
    end
    chk(q_rd.size() == 0 && q_blk.size() == 0 && q_wr.size() == 0,
        "R8 block count consumed", 512'(q_rd.size() + q_blk.size() + q_wr.size()), 0);
    host_rd(16'hFE01, v);
    chk(v == rd[7:0], "R3 busy write ignored", 512'(v), 512'(rd[7:0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdata == 0 && !mem_re && !mem_we && !hash_req, "R1 reset outputs",
        512'({host_rdata, mem_re, mem_we, hash_req}), 0);
    host_rd(16'hFE00, v);
    chk(v == 0, "R1 idle state code", 512'(v), 0);
    for (int k = 1; k <= 6; k++) host_wr(16'hFE00 | 16'(k), 8'(8'h10 * k + k));
    for (int k = 1; k <= 6; k++) begin
      host_rd(16'hFE00 | 16'(k), v);
      chk(v == 8'(8'h10 * k + k), "R2 register readback", 512'(v), 512'(8'h10 * k + k));
    end
    host_rd(16'hFE07, v);  chk(v == 0, "R2 unmapped offset 7", 512'(v), 0);
    host_rd(16'hFE0F, v);  chk(v == 0, "R2 unmapped offset 15", 512'(v), 0);
    host_wr(16'hFD01, 8'h77);
    host_rd(16'hFE01, v);  chk(v == 8'h11, "R2 out-of-window write", 512'(v), 512'h11);
    host_rd(16'hFE06, v);
    host_rd(16'h1234, v);  chk(v == 8'h66, "R11 out-of-window read holds", 512'(v), 512'h66);
    cmd = 2'd3; cmd_addr = 16'hFE00; @(negedge clk); cmd = 2'd0;
    chk(host_rdata == 8'h66, "R11 other command holds", 512'(host_rdata), 512'h66);
    host_wr(16'hFE00, 8'h03);
    host_rd(16'hFE00, v);  chk(v == 0, "R4 non-start code ignored", 512'(v), 0);

    run_op(16'h1000, 16'h2000, 16'd64, 1'b1, 0);
    run_op(16'hFFF0, 16'h3000, 16'd130, 1'b0, 1);
    run_op(16'h0040, 16'hFFF8, 16'd0, 1'b1, 2);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule